// File: doc/BRIEF.md
# Non-Restoring Division Step Unit

This block performs binary division one quotient bit per cycle with the non-restoring method. It holds a partial remainder register, a quotient/dividend shift register, the latched divisor and three status flags. Q is the sign of the partial remainder. M is the sign of the divisor. T is the most recent quotient bit. Whether a step adds or subtracts the divisor depends only on whether the previous Q matches M. No trial subtraction is made.

A setup command latches the operands and loads the flags for either a signed or an unsigned division. The caller then issues step strobes. Each accepted step shifts the next dividend bit into the remainder and shifts the new quotient bit into the quotient register. After the word-width count of steps the unit reports done. The raw non-restoring results are exposed as they stand: the remainder register together with Q forms the signed partial remainder, and the quotient register holds the collected quotient bits. Any final sign correction is left to the consumer.

Top module: `nrdiv_step_top`

## Requirements
- R1: After synchronous reset, remainder, quotient register, Q, M, T, busy, done and the status word are all zero.
- R2: An unsigned setup (mode input low) clears Q, M, T and the remainder, loads the quotient register with the dividend, raises busy and clears done.
- R3: A signed setup loads the remainder with copies of the dividend sign bit, sets Q to the dividend sign and M to the divisor sign, and sets T to Q XOR M.
- R4: On each accepted step, the new Q is the sign (bit 32) of the 33-bit value {old remainder, shifted-in bit} minus the divisor when the old Q equals M, or plus the divisor when they differ. The divisor is sign-extended when M is 1 and zero-extended when M is 0. The shifted-in bit is the quotient register's MSB. The remainder takes the low 32 bits of that result, and M does not change.
- R5: After each step, T is 1 exactly when the new Q equals M, and the quotient register shifts left by one with that T entering bit 0.
- R6: The status output is 10 bits wide: T at bit 0, Q at bit 8, M at bit 9, and all other bits zero.
- R7: The step that completes the count of 32 accepted steps drops busy and raises done on the same edge. Done stays high until the next setup, and busy and done are never high together.
- R8: A step strobe while no division is active (before any setup, or after done) changes no output.
- R9: A setup during a division in progress restarts the count from the new operands. The later result equals that of an uninterrupted division.
- R10: For unsigned operands with a nonzero divisor, after 32 steps the quotient register equals the integer quotient. The remainder equals the signed value {Q, remainder}, with the divisor added back when Q is 1.
- R11: For signed operands with a nonzero divisor, the raw outputs give the integer quotient and remainder once the standard non-restoring correction is applied. Let T0 be the T loaded at setup. The raw quotient is (quotient register with bit 0 cleared) + 1 - (T0 ? 2^32 : 0), and the raw remainder is the signed value {Q, remainder}. The correction makes the remainder take the sign of the dividend, then folds a remainder equal to plus or minus the divisor into the quotient. This holds for divisors 1 and -1 and for the most negative dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_i | input | 1 | Latch operands and start a division (overrides step) |
| signed_i | input | 1 | Division mode at setup: 1 signed, 0 unsigned |
| dividend_i | input | 32 | Dividend, sampled on setup |
| divisor_i | input | 32 | Divisor, sampled on setup |
| step_i | input | 1 | Perform one division iteration when busy |
| rem_o | output | 32 | Partial remainder register |
| quo_o | output | 32 | Quotient/dividend shift register |
| q_o | output | 1 | Remainder sign flag Q |
| m_o | output | 1 | Divisor sign flag M |
| t_o | output | 1 | Latest quotient bit T |
| status_o | output | 10 | Packed flag word |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | All steps of the current division have run |

## Verification
The assertions assume that setup and step are never unknown after reset, and that the operands matter only in the cycle setup is high. They also assume that setup wins over a simultaneous step. The flag and remainder relations hold only while the partial remainder stays inside the 33-bit range. That requires a nonzero divisor, so the stimulus never issues a zero divisor. All inputs change half a cycle away from the sampling edge and are driven to known values from time zero. The random and corner operands include divisors of 1, -1 and all ones, the most negative and most positive dividends, and a zero dividend, so the sign-tracking paths for both M values are exercised.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    // Flag set carried through the datapath
    typedef struct packed {
        logic q;   // partial remainder sign
        logic m;   // divisor sign
        logic t;   // latest quotient bit
    } flags_t;

    // Operation chosen by the sequencer for the current cycle
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_SETUP = 2'd1,
        OP_STEP  = 2'd2
    } op_e;

    // Status word layout (neighbouring logic decodes these positions)
    localparam int unsigned ST_W   = 10;
    localparam int unsigned ST_T_B = 0;
    localparam int unsigned ST_Q_B = 8;
    localparam int unsigned ST_M_B = 9;

    function automatic logic [ST_W-1:0] pack_status(input flags_t f);
        logic [ST_W-1:0] w;
        w         = '0;
        w[ST_T_B] = f.t;
        w[ST_Q_B] = f.q;
        w[ST_M_B] = f.m;
        return w;
    endfunction

endpackage

// File: rtl/nrdiv_init.sv
module nrdiv_init
    import nrdiv_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         signed_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] rem_o,
    output flags_t       flags_o
);

    logic dvd_neg;
    logic dvs_neg;

    always_comb begin
        dvd_neg    = signed_i & dividend_i[W-1];
        dvs_neg    = signed_i & divisor_i[W-1];
        rem_o      = {W{dvd_neg}};
        flags_o.q  = dvd_neg;
        flags_o.m  = dvs_neg;
        flags_o.t  = dvd_neg ^ dvs_neg;
    end

endmodule

// File: rtl/nrdiv_alu.sv
module nrdiv_alu
    import nrdiv_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] dsor_i,
    input  logic         bit_i,
    input  flags_t       flags_i,
    output logic [W-1:0] rem_o,
    output flags_t       flags_o
);

    logic [W-1:0] shifted;
    logic [W-1:0] result;
    logic         lost_msb;
    logic         do_sub;
    logic         cy;
    logic         q_new;

    always_comb begin
        lost_msb = rem_i[W-1];
        shifted  = {rem_i[W-2:0], bit_i};
        do_sub   = (flags_i.q == flags_i.m);
        if (do_sub) begin
            result = shifted - dsor_i;
            cy     = (result > shifted);   // borrow by unsigned compare
        end else begin
            result = shifted + dsor_i;
            cy     = (result < shifted);   // carry by unsigned compare
        end
        q_new      = lost_msb ^ cy ^ flags_i.m;
        rem_o      = result;
        flags_o.q  = q_new;
        flags_o.m  = flags_i.m;
        flags_o.t  = (q_new == flags_i.m);
    end

endmodule

// File: rtl/nrdiv_ctl.sv
module nrdiv_ctl
    import nrdiv_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic setup_i,
    input  logic step_i,
    output op_e  op_o,
    output logic busy_o,
    output logic done_o
);

    localparam int unsigned CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          done_q;

    always_comb begin
        if (setup_i)
            op_o = OP_SETUP;
        else if (step_i && busy_q)
            op_o = OP_STEP;
        else
            op_o = OP_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            unique case (op_o)
                OP_SETUP: begin
                    cnt_q  <= '0;
                    busy_q <= 1'b1;
                    done_q <= 1'b0;
                end
                OP_STEP: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;

    // R7
    finish_step_chk: assert property (@(posedge clk) disable iff (rst)
        (op_o == OP_STEP && cnt_q == LAST) |=> (done_q && !busy_q));

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy_q && done_q));

    // R9
    setup_restart_chk: assert property (@(posedge clk) disable iff (rst)
        setup_i |=> (busy_q && !done_q && cnt_q == '0));

endmodule

// File: rtl/nrdiv_step_top.sv
module nrdiv_step_top
    import nrdiv_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            setup_i,
    input  logic            signed_i,
    input  logic [W-1:0]    dividend_i,
    input  logic [W-1:0]    divisor_i,
    input  logic            step_i,
    output logic [W-1:0]    rem_o,
    output logic [W-1:0]    quo_o,
    output logic            q_o,
    output logic            m_o,
    output logic            t_o,
    output logic [ST_W-1:0] status_o,
    output logic            busy_o,
    output logic            done_o
);

    op_e          op;
    logic [W-1:0] rem_q;
    logic [W-1:0] quo_q;
    logic [W-1:0] dsor_q;
    flags_t       flags_q;

    logic [W-1:0] init_rem;
    flags_t       init_flags;
    logic [W-1:0] alu_rem;
    flags_t       alu_flags;

    nrdiv_ctl #(.W(W)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .setup_i (setup_i),
        .step_i  (step_i),
        .op_o    (op),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    nrdiv_init #(.W(W)) u_init (
        .signed_i   (signed_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .rem_o      (init_rem),
        .flags_o    (init_flags)
    );

    nrdiv_alu #(.W(W)) u_alu (
        .rem_i   (rem_q),
        .dsor_i  (dsor_q),
        .bit_i   (quo_q[W-1]),
        .flags_i (flags_q),
        .rem_o   (alu_rem),
        .flags_o (alu_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q   <= '0;
            quo_q   <= '0;
            dsor_q  <= '0;
            flags_q <= '0;
        end else begin
            unique case (op)
                OP_SETUP: begin
                    rem_q   <= init_rem;
                    quo_q   <= dividend_i;
                    dsor_q  <= divisor_i;
                    flags_q <= init_flags;
                end
                OP_STEP: begin
                    rem_q   <= alu_rem;
                    quo_q   <= {quo_q[W-2:0], alu_flags.t};
                    flags_q <= alu_flags;
                end
                default: ;
            endcase
        end
    end

    assign rem_o    = rem_q;
    assign quo_o    = quo_q;
    assign q_o      = flags_q.q;
    assign m_o      = flags_q.m;
    assign t_o      = flags_q.t;
    assign status_o = pack_status(flags_q);

    // R2
    unsigned_setup_chk: assert property (@(posedge clk) disable iff (rst)
        (setup_i && !signed_i) |=>
            (flags_q == '0 && rem_q == '0 && quo_q == $past(dividend_i)));

    // R3
    signed_setup_chk: assert property (@(posedge clk) disable iff (rst)
        (setup_i && signed_i) |=>
            (flags_q.q == $past(dividend_i[W-1]) &&
             flags_q.m == $past(divisor_i[W-1]) &&
             flags_q.t == (flags_q.q ^ flags_q.m)));

    // R5
    quotient_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP) |=>
            (flags_q.t == (flags_q.q == flags_q.m) &&
             quo_q[0] == flags_q.t &&
             quo_q[W-1:1] == $past(quo_q[W-2:0])));

    // R4
    divisor_sign_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP) |=> (flags_q.m == $past(flags_q.m) && $stable(dsor_q)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE) |=> ($stable(rem_q) && $stable(quo_q) && $stable(flags_q)));

endmodule

// File: tb/nrdiv_step_top_test.sv
`timescale 1ns/1ps
module nrdiv_step_top_test;

    localparam int W = 32;
    localparam longint TWO32 = 64'sh1_0000_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          setup_i = 1'b0;
    logic          signed_i = 1'b0;
    logic [W-1:0]  dividend_i = '0;
    logic [W-1:0]  divisor_i = '0;
    logic          step_i = 1'b0;
    logic [W-1:0]  rem_o;
    logic [W-1:0]  quo_o;
    logic          q_o, m_o, t_o;
    logic [9:0]    status_o;
    logic          busy_o, done_o;

    int checks = 0;
    int fails  = 0;

    // Behavioural model state
    longint       mP = 0;
    longint       mDv = 0;
    logic [31:0]  mQuo = '0;
    bit           mQ = 0, mM = 0, mT = 0, mT0 = 0;
    bit           mBusy = 0, mDone = 0;
    int           mCnt = 0;

    always #10 clk = ~clk;

    nrdiv_step_top uut (
        .clk(clk), .rst(rst), .setup_i(setup_i), .signed_i(signed_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i), .step_i(step_i),
        .rem_o(rem_o), .quo_o(quo_o), .q_o(q_o), .m_o(m_o), .t_o(t_o),
        .status_o(status_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        longint st_exp;
        st_exp = (longint'(mM) << 9) | (longint'(mQ) << 8) | longint'(mT);
        chk(tag,  "rem",    longint'(rem_o), longint'(mP[31:0]));
        chk(tag,  "Q",      longint'(q_o),   longint'(mQ));
        chk(tag,  "M",      longint'(m_o),   longint'(mM));
        chk("R5", "T",      longint'(t_o),   longint'(mT));
        chk("R5", "quo",    longint'(quo_o), longint'(mQuo));
        chk("R6", "status", longint'(status_o), st_exp);
        chk("R7", "busy",   longint'(busy_o), longint'(mBusy));
        chk("R7", "done",   longint'(done_o), longint'(mDone));
    endtask

    // One clock: drive after a falling edge, update model at the rising edge,
    // compare at the following falling edge.
    task automatic cyc(input bit su, input bit sg, input logic [31:0] a,
                       input logic [31:0] b, input bit st, input string tag);
        bit pneg;
        bit inb;
        setup_i = su; signed_i = sg; dividend_i = a; divisor_i = b; step_i = st;
        @(posedge clk);
        if (su) begin
            mP    = (sg && a[31]) ? -1 : 0;
            mQuo  = a;
            mDv   = sg ? longint'($signed(b)) : longint'(b);
            mQ    = sg && a[31];
            mM    = sg && b[31];
            mT    = mQ ^ mM;
            mT0   = mT;
            mBusy = 1; mDone = 0; mCnt = 0;
        end else if (st && mBusy) begin
            inb  = mQuo[31];
            pneg = (mP < 0);
            mP   = 2 * mP + longint'(inb);
            if (pneg == mM) mP = mP - mDv;
            else            mP = mP + mDv;
            mQ   = (mP < 0);
            mT   = (mQ == mM);
            mQuo = {mQuo[30:0], mT};
            mCnt++;
            if (mCnt == 32) begin mBusy = 0; mDone = 1; end
        end
        @(negedge clk);
        setup_i = 0; step_i = 0;
        compare_all(tag);
    endtask

    task automatic final_unsigned(input logic [31:0] a, input logic [31:0] b);
        longint r;
        r = q_o ? longint'(rem_o) - TWO32 : longint'(rem_o);
        if (q_o) r = r + longint'(b);
        chk("R10", "quotient",  longint'(quo_o), longint'(a) / longint'(b));
        chk("R10", "remainder", r,               longint'(a) % longint'(b));
    endtask

    task automatic final_signed(input logic [31:0] a, input logic [31:0] b);
        longint dd, dv, q, r;
        dd = longint'($signed(a));
        dv = longint'($signed(b));
        q  = (longint'(quo_o) & ~64'sd1) + 1 - (mT0 ? TWO32 : 0);
        r  = q_o ? longint'(rem_o) - TWO32 : longint'(rem_o);
        if (r != 0 && ((r < 0) != (dd < 0))) begin
            if ((r < 0) == (dv < 0)) begin q = q + 1; r = r - dv; end
            else                     begin q = q - 1; r = r + dv; end
        end
        if (r == dv)       begin q = q + 1; r = 0; end
        else if (r == -dv) begin q = q - 1; r = 0; end
        chk("R11", "quotient",  q, dd / dv);
        chk("R11", "remainder", r, dd % dv);
    endtask

    task automatic run_div(input logic [31:0] a, input logic [31:0] b, input bit sg,
                           input string setup_tag);
        cyc(1, sg, a, b, 0, setup_tag);
        for (int i = 0; i < 32; i++) cyc(0, 0, '0, '0, 1, "R4");
        chk("R7", "done after last step", longint'(done_o), 1);
        if (sg) final_signed(a, b);
        else    final_unsigned(a, b);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] a, b;
        repeat (3) @(negedge clk);
        rst = 0;
        compare_all("R1");
        chk("R1", "reset busy", longint'(busy_o), 0);

        // R8: steps before any setup
        for (int i = 0; i < 3; i++) cyc(0, 0, 32'h1234, 32'h5, 1, "R8");

        // R10 corners
        run_div(32'd1000, 32'd1, 0, "R2");
        run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R2");
        run_div(32'd5, 32'hFFFF_FFFF, 0, "R2");
        run_div(32'd0, 32'd7, 0, "R2");
        run_div(32'hFFFF_FFFF, 32'd3, 0, "R2");

        // R8: steps after done
        for (int i = 0; i < 2; i++) cyc(0, 0, '0, '0, 1, "R8");

        // R11 corners
        run_div(32'h8000_0000, 32'd1, 1, "R3");
        run_div(32'h8000_0000, 32'hFFFF_FFFF, 1, "R3");
        run_div(32'h8000_0000, 32'h8000_0000, 1, "R3");
        run_div(32'h8000_0000, 32'd3, 1, "R3");
        run_div(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, "R3");
        run_div(32'd7, 32'hFFFF_FFFF, 1, "R3");
        run_div(32'hFFFF_FFF9, 32'd2, 1, "R3");
        run_div(32'd0, 32'hFFFF_FFFB, 1, "R3");

        // R9: abort a division part way and start another
        cyc(1, 1, 32'hDEAD_BEEF, 32'd13, 0, "R3");
        for (int i = 0; i < 10; i++) cyc(0, 0, '0, '0, 1, "R4");
        run_div(32'd123456789, 32'd1000, 0, "R9");

        // Random unsigned and signed operands
        for (int i = 0; i < 30; i++) begin
            a = $urandom;
            b = $urandom;
            if (i % 3 == 0) b = b >> ($urandom % 32);
            if (b == 0) b = 1;
            run_div(a, b, 0, "R2");
        end
        for (int i = 0; i < 30; i++) begin
            a = $urandom;
            b = $urandom;
            if (i % 3 == 0) b = $signed(b) >>> ($urandom % 32);
            if (b == 0) b = 32'hFFFF_FFFF;
            run_div(a, b, 1, "R3");
        end

        summary();
        $finish;
    end

endmodule